// File: doc/BRIEF.md
# Dual Reference Clock Selector with Glitch-Free Changeover

This block chooses one of two single-ended reference clocks and forwards it on a single output toward a phase-detector path. The choice can be manual, taken either from a configuration bit or from an external select pin. It can also be automatic and revertive. In that case an external monitor flag reports that the preferred reference has failed, the block moves to the other reference, and it moves back as soon as the flag clears. Either input can be named the preferred one. Automatic operation without return to the preferred input is not offered.

All logic runs on a free-running sampling clock that is faster than either reference. Each reference passes through a two-flop synchroniser, and the forwarded clock is rebuilt from the synchronised copy. Each input has an activity monitor. It reports the input present when a rising edge has been seen within a programmable window of sampling cycles. With the changeover guard enabled, the output is held low from the falling edge of the old reference until the next falling edge of the new one. The first edge after a change is therefore a full rising edge of the new reference. A change toward a reference that never toggles then never completes. Clearing the guard bit forces the change through at once.

Top module: `ref_switch`

## Requirements
- R1: While reset is asserted, ref_out, active_b, switching, present_a and present_b are all 0. Reference A (active_b = 0) is the selection out of reset.
- R2: A reference's present flag is 1 in the cycle after a rising edge of that reference is detected. It drops to 0 once cfg_window sampling cycles pass with no rising edge.
- R3: With cfg_auto = 0 and cfg_use_pin = 0, the selection follows cfg_sel_b (1 = reference B), and sel_pin has no effect.
- R4: With cfg_auto = 0 and cfg_use_pin = 1, the selection follows sel_pin (1 = reference B), and cfg_sel_b has no effect.
- R5: With cfg_auto = 1 and cfg_prefer_b = 0, the selection is B while prim_bad = 1 and returns to A when prim_bad = 0. The manual inputs have no effect.
- R6: With cfg_auto = 1 and cfg_prefer_b = 1, the roles swap: the selection is B while prim_bad = 0 and A while prim_bad = 1.
- R7: With cfg_deglitch = 1, switching is 1 during a change. Once ref_out falls during a change, it stays low until the change completes. Every high pulse on ref_out lasts a full high phase of a reference.
- R8: With cfg_deglitch = 1, a change toward a reference that has no clock never completes. switching stays 1, active_b keeps the old value, and ref_out stays low.
- R9: With cfg_deglitch = 0, a pending or new change completes at the next clock edge whether or not the target reference is present, and switching reads 0 afterwards.
- R10: When no change is pending, ref_out equals the selected reference input as sampled three clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a | input | 1 | Reference clock A |
| ref_b | input | 1 | Reference clock B |
| cfg_sel_b | input | 1 | Manual selection bit from configuration (1 = B) |
| sel_pin | input | 1 | Manual selection from external pin (1 = B) |
| cfg_use_pin | input | 1 | In manual mode, take the selection from sel_pin |
| cfg_auto | input | 1 | Automatic revertive mode |
| cfg_prefer_b | input | 1 | In automatic mode, B is the preferred reference |
| prim_bad | input | 1 | Monitor flag: the preferred reference is invalid |
| cfg_deglitch | input | 1 | Enable the glitch-free changeover guard |
| cfg_window | input | WIN_W | Presence window in sampling cycles |
| ref_out | output | 1 | Selected, rebuilt reference clock |
| active_b | output | 1 | Currently forwarded reference (1 = B) |
| switching | output | 1 | A guarded change is in progress |
| present_a | output | 1 | Activity seen on reference A |
| present_b | output | 1 | Activity seen on reference B |

## Verification
The bench checks each changeover for runt pulses and for any rise after the output has gone low. A design that released the new clock on its rising edge, or cut the old clock mid-phase, would fail those checks. A change is requested toward a silenced input to confirm it hangs with the output low. A design that completed such a change anyway, or let the old clock through, would be caught there. The bench then clears the guard bit and checks that the stuck change completes within one edge. The manual source that should be ignored is toggled on purpose in every mode. The automatic mode is run with both preference settings, so a design that did not return to the preferred input, or that ignored the preference bit, shows the wrong active_b.

// File: rtl/ref_switch.sv
module ref_switch #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_a,
  input  logic             ref_b,
  input  logic             cfg_sel_b,
  input  logic             sel_pin,
  input  logic             cfg_use_pin,
  input  logic             cfg_auto,
  input  logic             cfg_prefer_b,
  input  logic             prim_bad,
  input  logic             cfg_deglitch,
  input  logic [WIN_W-1:0] cfg_window,
  output logic             ref_out,
  output logic             active_b,
  output logic             switching,
  output logic             present_a,
  output logic             present_b
);

  typedef enum logic [1:0] {S_IDLE, S_OLD, S_NEW} state_t;

  state_t           state;
  logic [1:0]       sync1, sync2, sync3;
  logic [1:0]       rise, fall, present;
  logic [WIN_W-1:0] age [2];
  logic             tgt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= {ref_b, ref_a};
      sync2 <= sync1;
      sync3 <= sync2;
    end

  assign rise = sync2 & ~sync3;
  assign fall = ~sync2 & sync3;

  for (genvar i = 0; i < 2; i++) begin : g_mon
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                age[i] <= '1;
      else if (rise[i])          age[i] <= '0;
      else if (age[i] < cfg_window) age[i] <= age[i] + 1'b1;
    assign present[i] = age[i] < cfg_window;
  end

  assign present_a = present[0];
  assign present_b = present[1];

  assign tgt = cfg_auto    ? (prim_bad ? ~cfg_prefer_b : cfg_prefer_b)
             : cfg_use_pin ? sel_pin : cfg_sel_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      active_b <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (tgt != active_b) begin
            if (!cfg_deglitch) active_b <= tgt;
            else               state    <= S_OLD;
          end
        S_OLD:
          if (!cfg_deglitch) begin
            active_b <= tgt;
            state    <= S_IDLE;
          end else if (tgt == active_b) state <= S_IDLE;
          else if (fall[active_b])      state <= S_NEW;
        S_NEW:
          if (!cfg_deglitch || fall[tgt]) begin
            active_b <= tgt;
            state    <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ref_out <= 1'b0;
    else        ref_out <= (state == S_NEW) ? 1'b0 : sync2[active_b];

  assign switching = (state != S_IDLE);

  assert_present_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && cfg_window != '0) |=> present_a);

  assert_commit_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(active_b) && $past(cfg_deglitch)) |-> !ref_out);

  assert_stuck_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_deglitch && state == S_NEW && !fall[tgt]) |=> $stable(active_b));

  assert_bypass_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_deglitch |=> !switching);

endmodule

// File: tb/ref_switch_bench.sv
module ref_switch_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_a = 1'b0, ref_b = 1'b0;
  logic       cfg_sel_b = 1'b0, sel_pin = 1'b0, cfg_use_pin = 1'b0;
  logic       cfg_auto = 1'b0, cfg_prefer_b = 1'b0, prim_bad = 1'b0;
  logic       cfg_deglitch = 1'b1;
  logic [7:0] cfg_window = 8'd20;
  logic       ref_out, active_b, switching, present_a, present_b;

  int  n_chk = 0, n_bad = 0;
  bit  en_a = 0, en_b = 0;
  int  ca = 0, cb = 0;
  logic [2:0] ha = '0, hb = '0;
  bit  mon_en = 0, seen_fall = 0, run_ok = 0, prev_out = 0;
  int  run = 0, glitch_err = 0;

  ref_switch #(.WIN_W(8)) u_ref_switch (
    .clk, .rst_n, .ref_a, .ref_b, .cfg_sel_b, .sel_pin, .cfg_use_pin,
    .cfg_auto, .cfg_prefer_b, .prim_bad, .cfg_deglitch, .cfg_window,
    .ref_out, .active_b, .switching, .present_a, .present_b);

  always #5 clk = ~clk;

  // reference A: 8 cycles (4 high), reference B: 12 cycles (6 high)
  always @(negedge clk) begin
    ca = (ca + 1) % 8;
    cb = (cb + 1) % 12;
    ref_a = en_a && (ca < 4);
    ref_b = en_b && (cb < 6);
  end

  always @(posedge clk) begin
    ha <= {ha[1:0], ref_a};
    hb <= {hb[1:0], ref_b};
  end

  // R7 monitor: no runt high pulse, no rise after a fall during a change
  always @(negedge clk) begin
    if (mon_en) begin
      if (!prev_out && ref_out) begin run = 1; run_ok = 1; end
      else if (ref_out) run++;
      if (prev_out && !ref_out && run_ok && run < 4) glitch_err++;
      if (switching && prev_out && !ref_out) seen_fall = 1;
      if (switching && seen_fall && ref_out) glitch_err++;
      if (!switching) seen_fall = 0;
    end else begin
      run_ok = 0;
      seen_fall = 0;
    end
    prev_out = ref_out;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    wcyc(3);
    chk({ref_out, active_b, switching, present_a, present_b} == 5'b0, "R1 reset outputs",
        {ref_out, active_b, switching, present_a, present_b}, 0);
    rst_n = 1'b1;
    en_a = 1; en_b = 1;
    wcyc(30);
  endtask

  task automatic t_presence;
    chk(present_a && present_b, "R2 both present", {present_a, present_b}, 3);
    en_b = 0;
    wcyc(5);
    chk(present_b, "R2 present inside window", present_b, 1);
    wcyc(25);
    chk(!present_b && present_a, "R2 absent after window", {present_a, present_b}, 2);
    en_b = 1;
    wcyc(30);
    chk(present_b, "R2 present again", present_b, 1);
  endtask

  task automatic t_track(string req);
    bit ok = 1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (ref_out !== (active_b ? hb[2] : ha[2])) ok = 0;
    end
    chk(ok, req, ref_out, active_b ? hb[2] : ha[2]);
  endtask

  task automatic t_manual_reg;
    mon_en = 1; glitch_err = 0;
    cfg_use_pin = 0; sel_pin = 1;
    wcyc(40);
    chk(active_b == 0, "R3 pin ignored", active_b, 0);
    t_track("R10 tracks A");
    cfg_sel_b = 1;
    wcyc(2);
    chk(switching == 1, "R7 switching flag", switching, 1);
    wcyc(38);
    chk(active_b == 1 && !switching, "R3 reg bit selects B", active_b, 1);
    t_track("R10 tracks B");
    sel_pin = 0;
    wcyc(40);
    chk(active_b == 1, "R3 pin ignored", active_b, 1);
    cfg_sel_b = 0;
    wcyc(40);
    chk(active_b == 0, "R3 reg bit selects A", active_b, 0);
    chk(glitch_err == 0, "R7 no glitch", glitch_err, 0);
  endtask

  task automatic t_manual_pin;
    glitch_err = 0;
    cfg_use_pin = 1; sel_pin = 1; cfg_sel_b = 0;
    wcyc(40);
    chk(active_b == 1, "R4 pin selects B", active_b, 1);
    cfg_sel_b = 1;
    wcyc(40);
    sel_pin = 0;
    wcyc(40);
    chk(active_b == 0, "R4 reg bit ignored", active_b, 0);
    cfg_sel_b = 0; cfg_use_pin = 0;
    chk(glitch_err == 0, "R7 no glitch", glitch_err, 0);
  endtask

  task automatic t_auto;
    glitch_err = 0;
    cfg_auto = 1; cfg_prefer_b = 0; prim_bad = 1; cfg_sel_b = 0; sel_pin = 0;
    wcyc(40);
    chk(active_b == 1, "R5 fail to B", active_b, 1);
    prim_bad = 0; cfg_sel_b = 1; sel_pin = 1;
    wcyc(40);
    chk(active_b == 0, "R5 revert to A", active_b, 0);
    t_track("R10 tracks A in auto");
    cfg_prefer_b = 1;
    wcyc(40);
    chk(active_b == 1, "R6 preferred B", active_b, 1);
    prim_bad = 1;
    wcyc(40);
    chk(active_b == 0, "R6 fail to A", active_b, 0);
    prim_bad = 0;
    wcyc(40);
    chk(active_b == 1, "R6 revert to B", active_b, 1);
    cfg_auto = 0; cfg_prefer_b = 0; cfg_sel_b = 0; sel_pin = 0;
    wcyc(40);
    chk(active_b == 0 && glitch_err == 0, "R7 no glitch in auto", glitch_err, 0);
  endtask

  task automatic t_stuck;
    int highs = 0;
    en_b = 0;
    wcyc(30);
    cfg_sel_b = 1;
    wcyc(40);
    chk(switching && !active_b, "R8 change pending", {switching, active_b}, 2);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ref_out) highs++;
    end
    chk(highs == 0, "R8 output held low", highs, 0);
    chk(switching && !active_b, "R8 still pending", {switching, active_b}, 2);
    mon_en = 0;
    cfg_deglitch = 0;
    wcyc(2);
    chk(!switching && active_b, "R9 forced completion", {switching, active_b}, 1);
    cfg_sel_b = 0;
    wcyc(1);
    chk(!active_b, "R9 immediate change", active_b, 0);
    en_b = 1;
    wcyc(30);
    cfg_sel_b = 1;
    wcyc(1);
    chk(active_b && !switching, "R9 immediate to present B", {switching, active_b}, 1);
    cfg_sel_b = 0;
    wcyc(1);
    cfg_deglitch = 1;
    wcyc(10);
    chk(!active_b && !switching, "R9 back on A", {switching, active_b}, 0);
  endtask

  initial begin
    t_reset();
    t_presence();
    t_manual_reg();
    t_manual_pin();
    t_auto();
    t_stuck();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule